// File: doc/BRIEF.md
# Code Region Address Remapper

This block sits between the execution-side fetch address of an instruction cache and the two master ports the cache uses to reach memory. It holds a small table of programmable regions. Each region has an enable, an aliased sub-region base, a size exponent, a destination physical base and a port select. Every incoming 32-bit address is compared against all enabled regions at once. The compare width of each region follows its own size exponent. On a hit, the upper address bits are replaced by the destination base, and the transfer is steered to the port that the region selects. Flash traffic and remapped SRAM traffic can therefore travel on separate ports.

Addresses enter on a valid/ready stream and leave on a second valid/ready stream after one register stage. An input beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the downstream side is taking its beat. While `out_valid` is high and `out_ready` is low, the output beat is frozen and no new address is accepted. Regions are written through a plain single-cycle write port. A write takes effect at the edge that samples it.

Top module: `code_region_remap`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high and every region is disabled, so every address passes through unchanged to port 0.
- R2: An enabled region with effective size exponent S hits when address bits [31:29] are zero and address bits [28:S] equal bits [28:S] of its sub-region base. The 8-bit field `cfg_sub_base` supplies address bits [28:21]. An address that differs in any of these bits does not hit.
- R3: A disabled region never hits, whatever its other fields hold.
- R4: A written size exponent below 21 is treated as 21, and one above 27 is treated as 27.
- R5: On a hit, bits [31:S] of the output address come from the destination base and bits [S-1:0] come from the input address. The 11-bit field `cfg_dest_base` supplies output bits [31:21]. Sub-base bits below S do not affect matching.
- R6: On a hit, `out_port` equals the port select of the winning region. On no hit, `out_port` is 0 and `out_addr` equals the input address.
- R7: When several enabled regions hit, the region with the lowest index decides both the address and the port.
- R8: An address accepted at edge N appears on `out_addr`/`out_port` with `out_valid` high after edge N. If no beat is accepted and the held beat is taken, `out_valid` falls after that edge.
- R9: `in_ready` is low while `out_valid` is high and `out_ready` is low. During that time `out_addr` and `out_port` do not change.
- R10: A configuration write updates its region at the edge that samples `cfg_wr`. An address accepted at that same edge is translated with the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for one region |
| cfg_idx | input | 2 | Index of the region to write |
| cfg_enable | input | 1 | Region enable value |
| cfg_sub_base | input | 8 | Aliased base, address bits [28:21] |
| cfg_size_exp | input | 5 | Size exponent, log2 of region bytes (clamped) |
| cfg_dest_base | input | 11 | Destination base, output bits [31:21] |
| cfg_port_sel | input | 1 | Master port for hits in this region |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Input address accepted when high with in_valid |
| in_addr | input | 32 | Fetch address |
| out_valid | output | 1 | Translated address valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_addr | output | 32 | Translated or passed-through address |
| out_port | output | 1 | Master port select (0 or 1) |

## Verification
Each translated address and port is due exactly one clock edge after its input beat is accepted. The bench drives an address on a falling edge. On that same falling edge it confirms that the output register is still empty. It reads the result on the next falling edge, which follows the single capturing edge. Configuration writes and stalls are timed the same way. In the same-edge write case the bench expects the old mapping on the following falling edge. During a stall it expects the held beat, and `in_ready` low, on every falling edge until `out_ready` returns.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W    = 32;
  localparam int RS_MIN    = 21;
  localparam int RS_MAX    = 27;
  localparam int ZERO_HI   = 3;
  localparam int ALIAS_TOP = ADDR_W - ZERO_HI - 1;
  localparam int SUB_W     = ALIAS_TOP - RS_MIN + 1;
  localparam int DEST_W    = ADDR_W - RS_MIN;
  localparam int EXP_W     = $clog2(ADDR_W);

  typedef struct packed {
    logic              en;
    logic [SUB_W-1:0]  sub_base;
    logic [EXP_W-1:0]  size_exp;
    logic [DEST_W-1:0] dest_base;
    logic              port_sel;
  } region_t;

  // bit j covers address bit RS_MIN+j; set when that bit lies at or above the size exponent
  function automatic logic [DEST_W-1:0] upper_mask(input logic [EXP_W-1:0] rs);
    logic [DEST_W-1:0] m;
    for (int j = 0; j < DEST_W; j++) m[j] = (int'(rs) <= RS_MIN + j);
    return m;
  endfunction

  function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] raw);
    if (int'(raw) < RS_MIN) return EXP_W'(RS_MIN);
    if (int'(raw) > RS_MAX) return EXP_W'(RS_MAX);
    return raw;
  endfunction
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
#(
  parameter int NUM_REG = 4,
  localparam int IDX_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  region_t                   wr_data,
  output region_t [NUM_REG-1:0]     regions_o
);
  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regions_o[r] <= '0;
      end else if (wr_en && (int'(wr_idx) == r)) begin
        regions_o[r]          <= wr_data;
        regions_o[r].size_exp <= clamp_exp(wr_data.size_exp);
      end
    end
  end
endmodule

// File: rtl/remap_match.sv
module remap_match
  import remap_pkg::*;
#(
  parameter int NUM_REG = 4
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  region_t [NUM_REG-1:0]           regions_i,
  output logic [NUM_REG-1:0]              hits_o,
  output logic [NUM_REG-1:0][ADDR_W-1:0]  xlat_o
);
  for (genvar r = 0; r < NUM_REG; r++) begin : g_cmp
    logic [DEST_W-1:0] m;
    logic [DEST_W-1:0] upper;
    logic [SUB_W-1:0]  diff;
    always_comb begin
      m     = upper_mask(regions_i[r].size_exp);
      upper = addr_i[ADDR_W-1:RS_MIN];
      diff  = (addr_i[ALIAS_TOP:RS_MIN] ^ regions_i[r].sub_base) & m[SUB_W-1:0];
      hits_o[r] = regions_i[r].en && (addr_i[ADDR_W-1:ALIAS_TOP+1] == '0) && (diff == '0);
      xlat_o[r] = {(regions_i[r].dest_base & m) | (upper & ~m), addr_i[RS_MIN-1:0]};
    end
  end
endmodule

// File: rtl/remap_pick.sv
module remap_pick
  import remap_pkg::*;
#(
  parameter int NUM_REG = 4
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [NUM_REG-1:0]              hits_i,
  input  logic [NUM_REG-1:0][ADDR_W-1:0]  xlat_i,
  input  region_t [NUM_REG-1:0]           regions_i,
  output logic                            hit_any_o,
  output logic [ADDR_W-1:0]               addr_o,
  output logic                            port_o
);
  // walk from the top index down so the lowest hitting index is written last
  always_comb begin
    hit_any_o = |hits_i;
    addr_o    = addr_i;
    port_o    = 1'b0;
    for (int r = NUM_REG - 1; r >= 0; r--) begin
      if (hits_i[r]) begin
        addr_o = xlat_i[r];
        port_o = regions_i[r].port_sel;
      end
    end
  end
endmodule

// File: rtl/remap_pipe.sv
module remap_pipe #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_addr,
  input  logic              in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_addr,
  output logic              out_port
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_port  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= in_addr;
        out_port <= in_port;
      end
    end
  end
endmodule

// File: rtl/code_region_remap.sv
module code_region_remap
  import remap_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_enable,
  input  logic [SUB_W-1:0]  cfg_sub_base,
  input  logic [EXP_W-1:0]  cfg_size_exp,
  input  logic [DEST_W-1:0] cfg_dest_base,
  input  logic              cfg_port_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_port
);
  region_t                              wr_data;
  region_t [NUM_REGIONS-1:0]            regions;
  logic [NUM_REGIONS-1:0]               hits;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0]   xlat;
  logic                                 hit_any;
  logic [ADDR_W-1:0]                    sel_addr;
  logic                                 sel_port;

  assign wr_data = '{en: cfg_enable, sub_base: cfg_sub_base, size_exp: cfg_size_exp,
                     dest_base: cfg_dest_base, port_sel: cfg_port_sel};

  remap_cfg_regs #(.NUM_REG(NUM_REGIONS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_idx(cfg_idx),
    .wr_data(wr_data), .regions_o(regions)
  );

  remap_match #(.NUM_REG(NUM_REGIONS)) u_match (
    .addr_i(in_addr), .regions_i(regions), .hits_o(hits), .xlat_o(xlat)
  );

  remap_pick #(.NUM_REG(NUM_REGIONS)) u_pick (
    .addr_i(in_addr), .hits_i(hits), .xlat_i(xlat), .regions_i(regions),
    .hit_any_o(hit_any), .addr_o(sel_addr), .port_o(sel_port)
  );

  remap_pipe #(.DATA_W(ADDR_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(sel_addr), .in_port(sel_port),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_port(out_port)
  );
endmodule

// File: rtl/code_region_remap_chk.sv
module code_region_remap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_addr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_addr,
  input logic        out_port,
  input logic        hit_any
);
  a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r8_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_port));

  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r6_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !hit_any |=> (out_addr == $past(in_addr)) && !out_port);
endmodule

bind code_region_remap code_region_remap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_port(out_port),
  .hit_any(hit_any)
);

// File: tb/code_region_remap_tb_top.sv
`timescale 1ns/1ps
module code_region_remap_tb_top;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_enable = 1'b0;
  logic [7:0]  cfg_sub_base = '0;
  logic [4:0]  cfg_size_exp = '0;
  logic [10:0] cfg_dest_base = '0;
  logic        cfg_port_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_port;

  int vectors = 0;
  int fails = 0;
  logic [31:0] lf = 32'h1234_5678;

  bit          m_en   [NR];
  logic [7:0]  m_sub  [NR];
  logic [4:0]  m_size [NR];
  logic [10:0] m_dest [NR];
  bit          m_port [NR];

  always #2 clk = ~clk;

  code_region_remap dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_enable(cfg_enable),
    .cfg_sub_base(cfg_sub_base), .cfg_size_exp(cfg_size_exp), .cfg_dest_base(cfg_dest_base),
    .cfg_port_sel(cfg_port_sel), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_port(out_port)
  );

  function automatic int eff_exp(input logic [4:0] raw);
    if (raw < 21) return 21;
    if (raw > 27) return 27;
    return int'(raw);
  endfunction

  function automatic void model(input logic [31:0] a, output logic [31:0] ea, output bit ep);
    ea = a;
    ep = 1'b0;
    for (int r = NR - 1; r >= 0; r--) begin
      int rs;
      logic [31:0] base;
      logic [31:0] dst;
      rs   = eff_exp(m_size[r]);
      base = {3'b000, m_sub[r], 21'd0};
      dst  = {m_dest[r], 21'd0};
      if (m_en[r] && ((a >> rs) == (base >> rs))) begin
        ea = ((dst >> rs) << rs) | (a & ((32'd1 << rs) - 32'd1));
        ep = m_port[r];
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step_lf();
    lf = lf * 32'd1664525 + 32'd1013904223;
  endtask

  task automatic cfg_write(input int idx, input bit en, input logic [7:0] sub,
                           input logic [4:0] sz, input logic [10:0] dest, input bit port);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 2'(idx); cfg_enable = en; cfg_sub_base = sub;
    cfg_size_exp = sz; cfg_dest_base = dest; cfg_port_sel = port;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_en[idx] = en; m_sub[idx] = sub; m_size[idx] = sz; m_dest[idx] = dest; m_port[idx] = port;
  endtask

  task automatic send(input logic [31:0] a, input string tag);
    logic [31:0] ea;
    bit ep;
    model(a, ea, ep);
    @(negedge clk);
    in_addr = a; in_valid = 1'b1;
    // R8: nothing accepted last edge, so the output register is still empty
    check(!out_valid && in_ready, "R8", {62'd0, out_valid, in_ready}, 64'd1);
    @(negedge clk);
    check(out_valid && out_addr == ea && out_port == ep, tag,
          {31'd0, out_valid, out_port, out_addr}, {31'd0, 1'b1, ep, ea});
    in_valid = 1'b0;
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_en[r] = 0; m_sub[r] = '0; m_size[r] = '0; m_dest[r] = '0; m_port[r] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty output, ready input, all regions off
    check(!out_valid && in_ready, "R1", {62'd0, out_valid, in_ready}, 64'd1);
    send(32'h0123_4567, "R1");
    send(32'h1FE0_0000, "R1");
    send(32'h0000_0000, "R1");

    // size exponent sweep on region 0, including clamped raw values
    for (int raw = 0; raw < 32; raw++) begin
      int rs;
      logic [31:0] base;
      logic [31:0] lowm;
      logic [31:0] a1;
      string th;
      rs   = eff_exp(5'(raw));
      base = {3'b000, 8'hA5, 21'd0};
      lowm = (32'd1 << rs) - 32'd1;
      th   = (raw < 21 || raw > 27) ? "R4" : "R5";
      step_lf();
      a1 = (base & ~lowm) | (lf & lowm);
      cfg_write(0, 1'b1, 8'hA5, 5'(raw), 11'h5C3, 1'b1);
      send(a1, th);
      send(a1 ^ (32'd1 << (rs - 1)), th);
      send(a1 ^ (32'd1 << rs), "R2");
      send(a1 | 32'h2000_0000, "R2");
      send(a1 ^ 32'h0020_0000, (rs > 21) ? "R5" : "R2");
      cfg_write(0, 1'b0, 8'hA5, 5'(raw), 11'h5C3, 1'b1);
      send(a1, "R3");
    end

    // priority over all enable patterns of four overlapping regions
    for (int pat = 0; pat < 16; pat++) begin
      logic [31:0] alist [8];
      alist[0] = 32'h0260_0123; alist[1] = 32'h0241_0100; alist[2] = 32'h0200_0004;
      alist[3] = 32'h0100_0000; alist[4] = 32'h0900_0000; alist[5] = 32'h027F_FFFC;
      alist[6] = 32'h07FF_FFF0; alist[7] = 32'h0240_0000;
      cfg_write(0, pat[0], 8'h10, 5'd27, 11'h100, 1'b0);
      cfg_write(1, pat[1], 8'h12, 5'd24, 11'h2AB, 1'b1);
      cfg_write(2, pat[2], 8'h13, 5'd22, 11'h3C0, 1'b0);
      cfg_write(3, pat[3], 8'h13, 5'd21, 11'h7FF, 1'b1);
      for (int k = 0; k < 8; k++) send(alist[k], (pat == 0) ? "R6" : "R7");
    end

    // R10: write and address on the same edge use the old mapping
    for (int r = 0; r < NR; r++) cfg_write(r, 1'b0, 8'h00, 5'd21, 11'h000, 1'b0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 2'd0; cfg_enable = 1'b1; cfg_sub_base = 8'h20;
    cfg_size_exp = 5'd21; cfg_dest_base = 11'h7FF; cfg_port_sel = 1'b1;
    in_valid = 1'b1; in_addr = 32'h0400_0ABC;
    @(negedge clk);
    cfg_wr = 1'b0; in_valid = 1'b0;
    m_en[0] = 1; m_sub[0] = 8'h20; m_size[0] = 5'd21; m_dest[0] = 11'h7FF; m_port[0] = 1;
    check(out_valid && out_addr == 32'h0400_0ABC && !out_port, "R10",
          {31'd0, out_valid, out_port, out_addr}, {31'd0, 1'b1, 1'b0, 32'h0400_0ABC});
    send(32'h0400_0ABC, "R10");

    // R9: back-pressure holds the beat and blocks input
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h0410_0001;
    @(negedge clk);
    in_addr = 32'h0123_0000;
    for (int w = 0; w < 3; w++) begin
      check(out_valid && !in_ready && out_addr == 32'hFFF0_0001 && out_port,
            "R9", {30'd0, out_valid, in_ready, out_addr}, {30'd0, 2'b10, 32'hFFF0_0001});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_addr == 32'h0123_0000 && !out_port, "R9",
          {31'd0, out_valid, out_port, out_addr}, {31'd0, 1'b1, 1'b0, 32'h0123_0000});
    @(negedge clk);
    check(!out_valid, "R8", {63'd0, out_valid}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule